// File: doc/BRIEF.md
# Split-Completion Retry Tracker

This block sits between the request decoder of a bus target and a slower internal back end. When an initiator first addresses the target, the tracker records the whole transaction and answers with a retry-style stop instead of completing it. The recorded fields are the command, the address, the byte enables and, for a write, the data. It then starts the real access on its back-end port and keeps the result. When the initiator later repeats exactly the same transaction, the tracker completes it from the stored result. For a read it returns the stored read data. For a write it signals completion.

The tracker holds one transaction at a time. Any other transaction that arrives while an entry is held is answered with a retry, and nothing from it is stored. A parameterised discard timer frees a result that nobody collects. Each discard raises a sticky flag, which software can clear. Byte enables are active high on every port of this block.

Front-end rules: a request is accepted on a clock edge where `fe_req_valid` and `fe_req_ready` are both high. Exactly one response cycle (`fe_rsp_valid`) follows on the next cycle, and the front end must take it with no back-pressure. `fe_req_ready` is low during that response cycle. Back-end rules: `be_req_valid` holds its fields stable until `be_req_ready` is seen. `be_rsp_valid` is taken only in a cycle where `be_rsp_ready` is high, and that is never the cycle of the request handshake.

Top module: `dtr_tracker`

## Requirements
- R1: After reset the status is idle (0), no response or back-end request is valid, and the discard flag is 0.
- R2: A request accepted while idle is captured and answered one cycle after acceptance with a response whose retry bit is 1; `fe_req_ready` is low in that response cycle.
- R3: Each captured transaction produces exactly one back-end request, held valid until `be_req_ready`, carrying the captured command, address, byte enables and write data.
- R4: A matching repeat that arrives before the back-end result is in is answered with retry, and the entry stays held.
- R5: A matching repeat that arrives while the result is ready is completed with the retry bit 0 and the stored read data, and the entry is freed (status idle).
- R6: A repeat matches only if command, address and byte enables are equal and, for a write command (command bit 0 = 1), the write data is also equal. A mismatch is answered with retry and leaves the stored entry unchanged.
- R7: A different transaction arriving while an entry is held is retried, is not captured, and starts no back-end request.
- R8: After DISCARD_CYCLES clock cycles in the ready state with no delivery, the entry is dropped (status idle) and the discard flag is set. A later repeat is then treated as a new first attempt.
- R9: A one-cycle pulse on `discard_clr` clears the discard flag; a new discard in the same cycle takes priority.
- R10: `dt_status` encodes 0 = idle, 1 = waiting for the back end, 2 = result ready.
- R11: `be_rsp_ready` is high only while waiting, after the back-end request has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, also the bus reset |
| fe_req_valid | input | 1 | Front-end transaction present |
| fe_req_ready | output | 1 | Tracker can accept a transaction |
| fe_req_cmd | input | CMD_W | Transaction command; bit 0 set means write |
| fe_req_addr | input | ADDR_W | Transaction address |
| fe_req_be | input | DATA_W/8 | Byte enables, active high |
| fe_req_wdata | input | DATA_W | Write data |
| fe_rsp_valid | output | 1 | Response for the transaction accepted one cycle earlier |
| fe_rsp_retry | output | 1 | 1 = stop and retry, 0 = completed |
| fe_rsp_rdata | output | DATA_W | Read data on completion, zero otherwise |
| be_req_valid | output | 1 | Back-end access request |
| be_req_ready | input | 1 | Back end takes the request |
| be_req_cmd | output | CMD_W | Captured command |
| be_req_addr | output | ADDR_W | Captured address |
| be_req_be | output | DATA_W/8 | Captured byte enables |
| be_req_wdata | output | DATA_W | Captured write data |
| be_rsp_valid | input | 1 | Back-end result present |
| be_rsp_ready | output | 1 | Tracker takes the back-end result |
| be_rsp_rdata | input | DATA_W | Back-end read data |
| dt_status | output | 2 | Entry status |
| discard_flag | output | 1 | Sticky flag: a result was discarded |
| discard_clr | input | 1 | Clears the discard flag |

## Verification
The hardest situation to reach is a result that waits the full discard window with no retry. It must then be dropped at the right moment, and the next identical request must be treated as fresh. The bench builds this case directly. It gets one transaction to the ready state, waits idle for just under the window and checks that the entry is still held, then waits past the window. A second hard case is a repeat that differs in only one field, such as the byte enables, the command or a single data byte of a write. Such repeats arrive while the back end is stalled or while the result is ready. The bench stalls its back-end model under control, and the random phase mixes in foreign addresses and varies the back-end latency and handshake timing.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
  typedef enum logic [1:0] {
    DT_IDLE  = 2'd0,
    DT_WAIT  = 2'd1,
    DT_READY = 2'd2
  } dt_state_e;

  // command bit that marks a write
  localparam int WR_BIT = 0;
endpackage

// File: rtl/dtr_entry.sv
module dtr_entry #(
  parameter int CMD_W  = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic [CMD_W-1:0]    in_cmd,
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [DATA_W/8-1:0] in_be,
  input  logic [DATA_W-1:0]   in_wdata,
  input  logic                res_en,
  input  logic [DATA_W-1:0]   res_data,
  output logic [CMD_W-1:0]    cmd_q,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [DATA_W/8-1:0] be_q,
  output logic [DATA_W-1:0]   wdata_q,
  output logic [DATA_W-1:0]   res_q,
  output logic                match
);
  import dtr_pkg::*;
  localparam int LANES = DATA_W / 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      cmd_q   <= in_cmd;
      addr_q  <= in_addr;
      be_q    <= in_be;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_data;
  end

  // per-lane compare of write data
  logic [LANES-1:0] lane_eq;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_eq[i] = (wdata_q[i*8 +: 8] == in_wdata[i*8 +: 8]);
  end

  logic hdr_eq, is_wr;
  assign hdr_eq = (cmd_q == in_cmd) && (addr_q == in_addr) && (be_q == in_be);
  assign is_wr  = cmd_q[WR_BIT];
  assign match  = hdr_eq && (!is_wr || (&lane_eq));
endmodule

// File: rtl/dtr_timer.sv
module dtr_timer #(
  parameter int LIMIT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run)          cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);

  // R8: counter restarts from zero whenever the ready window closes
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/dtr_ctrl.sv
module dtr_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fe_req_valid,
  output logic              fe_req_ready,
  input  logic              match,
  input  logic              expire,
  output logic              cap_en,
  output logic              be_req_valid,
  input  logic              be_req_ready,
  input  logic              be_rsp_valid,
  output logic              be_rsp_ready,
  output logic              res_en,
  output logic              timer_run,
  output logic              fe_rsp_valid,
  output logic              fe_rsp_retry,
  output logic [DATA_W-1:0] fe_rsp_rdata,
  input  logic [DATA_W-1:0] res_q,
  output logic [1:0]        dt_status,
  input  logic              discard_clr,
  output logic              discard_flag
);
  import dtr_pkg::*;

  dt_state_e st_q, st_d;
  logic issued_q, issued_d;
  logic rsp_v_q, rsp_retry_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic flag_q;
  logic acc, deliver, drop;

  assign fe_req_ready = !rsp_v_q;
  assign acc          = fe_req_valid && fe_req_ready;
  assign cap_en       = acc && (st_q == DT_IDLE);
  assign deliver      = acc && (st_q == DT_READY) && match;
  assign drop         = expire && !deliver;
  assign be_req_valid = (st_q == DT_WAIT) && !issued_q;
  assign be_rsp_ready = (st_q == DT_WAIT) && issued_q;
  assign res_en       = be_rsp_valid && be_rsp_ready;
  assign timer_run    = (st_q == DT_READY);

  always_comb begin
    st_d     = st_q;
    issued_d = issued_q;
    unique case (st_q)
      DT_IDLE: begin
        if (cap_en) begin
          st_d     = DT_WAIT;
          issued_d = 1'b0;
        end
      end
      DT_WAIT: begin
        if (!issued_q && be_req_ready) issued_d = 1'b1;
        if (res_en)                    st_d     = DT_READY;
      end
      DT_READY: begin
        if (deliver || drop) st_d = DT_IDLE;
      end
      default: st_d = DT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= DT_IDLE;
      issued_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      issued_q <= issued_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q     <= 1'b0;
      rsp_retry_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_v_q     <= acc;
      rsp_retry_q <= acc && !deliver;
      rsp_data_q  <= deliver ? res_q : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           flag_q <= 1'b0;
    else if (drop)        flag_q <= 1'b1;
    else if (discard_clr) flag_q <= 1'b0;
  end

  assign fe_rsp_valid = rsp_v_q;
  assign fe_rsp_retry = rsp_retry_q;
  assign fe_rsp_rdata = rsp_data_q;
  assign dt_status    = st_q;
  assign discard_flag = flag_q;

  // R2: every accepted request is answered on the following cycle
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_req_valid && fe_req_ready) |=> fe_rsp_valid);
  // R2: no new request is taken during a response cycle
  assert_no_accept_in_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fe_rsp_valid |-> !fe_req_ready);
  // R3: the back-end request is not repeated after it has been taken
  assert_issue_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (be_req_valid && be_req_ready) |=> !be_req_valid);
  // R5: a completed response leaves the tracker idle
  assert_free_on_deliver_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_rsp_valid && !fe_rsp_retry) |-> (dt_status == 2'd0));
  // R7: a mismatching request while held does not free the entry
  assert_hold_on_foreign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_req_valid && fe_req_ready && dt_status != 2'd0 && !match && !expire)
      |=> (dt_status != 2'd0));
  // R8: an expiry with no delivery drops the entry and sets the flag
  assert_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !(fe_req_valid && fe_req_ready && match))
      |=> (dt_status == 2'd0 && discard_flag));
  // R11: the back-end result port is open only while waiting
  assert_rsp_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    be_rsp_ready |-> (dt_status == 2'd1 && !be_req_valid));
endmodule

// File: rtl/dtr_tracker.sv
module dtr_tracker #(
  parameter int CMD_W          = 4,
  parameter int ADDR_W         = 32,
  parameter int DATA_W         = 32,
  parameter int DISCARD_CYCLES = 32768
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fe_req_valid,
  output logic                fe_req_ready,
  input  logic [CMD_W-1:0]    fe_req_cmd,
  input  logic [ADDR_W-1:0]   fe_req_addr,
  input  logic [DATA_W/8-1:0] fe_req_be,
  input  logic [DATA_W-1:0]   fe_req_wdata,
  output logic                fe_rsp_valid,
  output logic                fe_rsp_retry,
  output logic [DATA_W-1:0]   fe_rsp_rdata,
  output logic                be_req_valid,
  input  logic                be_req_ready,
  output logic [CMD_W-1:0]    be_req_cmd,
  output logic [ADDR_W-1:0]   be_req_addr,
  output logic [DATA_W/8-1:0] be_req_be,
  output logic [DATA_W-1:0]   be_req_wdata,
  input  logic                be_rsp_valid,
  output logic                be_rsp_ready,
  input  logic [DATA_W-1:0]   be_rsp_rdata,
  output logic [1:0]          dt_status,
  output logic                discard_flag,
  input  logic                discard_clr
);
  logic cap_en, res_en, match, expire, timer_run;
  logic [DATA_W-1:0] res_q;

  dtr_entry #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_entry (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .in_cmd   (fe_req_cmd),
    .in_addr  (fe_req_addr),
    .in_be    (fe_req_be),
    .in_wdata (fe_req_wdata),
    .res_en   (res_en),
    .res_data (be_rsp_rdata),
    .cmd_q    (be_req_cmd),
    .addr_q   (be_req_addr),
    .be_q     (be_req_be),
    .wdata_q  (be_req_wdata),
    .res_q    (res_q),
    .match    (match)
  );

  dtr_timer #(.LIMIT(DISCARD_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (timer_run),
    .expire (expire)
  );

  dtr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fe_req_valid (fe_req_valid),
    .fe_req_ready (fe_req_ready),
    .match        (match),
    .expire       (expire),
    .cap_en       (cap_en),
    .be_req_valid (be_req_valid),
    .be_req_ready (be_req_ready),
    .be_rsp_valid (be_rsp_valid),
    .be_rsp_ready (be_rsp_ready),
    .res_en       (res_en),
    .timer_run    (timer_run),
    .fe_rsp_valid (fe_rsp_valid),
    .fe_rsp_retry (fe_rsp_retry),
    .fe_rsp_rdata (fe_rsp_rdata),
    .res_q        (res_q),
    .dt_status    (dt_status),
    .discard_clr  (discard_clr),
    .discard_flag (discard_flag)
  );
endmodule

// File: tb/dtr_tracker_tb.sv
module dtr_tracker_tb;
  localparam int LIMIT = 32768;
  localparam logic [3:0] C_RD = 4'h6, C_WR = 4'h7, C_IORD = 4'h2, C_IOWR = 4'h3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fe_req_valid = 1'b0, fe_req_ready;
  logic [3:0] fe_req_cmd = '0;
  logic [31:0] fe_req_addr = '0;
  logic [3:0] fe_req_be = '0;
  logic [31:0] fe_req_wdata = '0;
  logic fe_rsp_valid, fe_rsp_retry;
  logic [31:0] fe_rsp_rdata;
  logic be_req_valid, be_req_ready;
  logic [3:0] be_req_cmd, be_req_be;
  logic [31:0] be_req_addr, be_req_wdata;
  logic be_rsp_valid, be_rsp_ready;
  logic [31:0] be_rsp_rdata;
  logic [1:0] dt_status;
  logic discard_flag, discard_clr = 1'b0;

  dtr_tracker #(.DISCARD_CYCLES(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fe_req_valid(fe_req_valid), .fe_req_ready(fe_req_ready),
    .fe_req_cmd(fe_req_cmd), .fe_req_addr(fe_req_addr),
    .fe_req_be(fe_req_be), .fe_req_wdata(fe_req_wdata),
    .fe_rsp_valid(fe_rsp_valid), .fe_rsp_retry(fe_rsp_retry), .fe_rsp_rdata(fe_rsp_rdata),
    .be_req_valid(be_req_valid), .be_req_ready(be_req_ready),
    .be_req_cmd(be_req_cmd), .be_req_addr(be_req_addr),
    .be_req_be(be_req_be), .be_req_wdata(be_req_wdata),
    .be_rsp_valid(be_rsp_valid), .be_rsp_ready(be_rsp_ready), .be_rsp_rdata(be_rsp_rdata),
    .dt_status(dt_status), .discard_flag(discard_flag), .discard_clr(discard_clr)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
  endfunction

  // back-end model
  int be_cnt = 0;
  bit be_hold = 0;
  int be_lat = 2;
  int be_cd = -1;
  bit fire_pend = 0;
  logic [31:0] pend_addr = '0, pend_wdata = '0;
  logic [3:0] pend_cmd = '0, pend_be = '0;

  initial begin
    be_req_ready = 1'b0; be_rsp_valid = 1'b0; be_rsp_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        be_req_ready = 1'b0; be_rsp_valid = 1'b0; be_cd = -1; fire_pend = 0;
      end else begin
        if (be_rsp_valid) be_rsp_valid = 1'b0;
        if (fire_pend) begin
          be_cnt++; be_cd = be_lat; fire_pend = 0;
        end else if (be_cd > 0) be_cd--;
        else if (be_cd == 0 && !be_hold) begin
          chk("R11", "be_rsp_ready when result offered", be_rsp_ready, 1);
          be_rsp_valid = 1'b1; be_rsp_rdata = exp_rd(pend_addr); be_cd = -1;
        end
        be_req_ready = (($urandom % 3) != 0);
        if (be_req_valid && be_req_ready) begin
          fire_pend = 1; pend_addr = be_req_addr; pend_cmd = be_req_cmd;
          pend_be = be_req_be; pend_wdata = be_req_wdata;
        end
      end
    end
  end

  task automatic send(input logic [3:0] c, input logic [31:0] a, input logic [3:0] b,
                      input logic [31:0] d, output bit retry, output logic [31:0] rd);
    @(negedge clk);
    fe_req_valid = 1'b1; fe_req_cmd = c; fe_req_addr = a; fe_req_be = b; fe_req_wdata = d;
    while (!fe_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    fe_req_valid = 1'b0;
    chk("R2", "response one cycle after accept", fe_rsp_valid, 1);
    retry = fe_rsp_retry; rd = fe_rsp_rdata;
  endtask

  task automatic wait_status(input logic [1:0] s);
    for (int i = 0; i < 300; i++) begin
      if (dt_status == s) return;
      @(negedge clk);
    end
    chk("R10", "status reached", dt_status, s);
  endtask

  initial begin
    int wd = 0;
    while (!finished) begin
      @(posedge clk);
      wd++;
      if (wd > 190000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    bit r; logic [31:0] rd;
    logic [31:0] a, d; logic [3:0] c, b; int base;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R10 reset state
    chk("R1", "status", dt_status, 0);
    chk("R1", "rsp valid", fe_rsp_valid, 0);
    chk("R1", "be_req_valid", be_req_valid, 0);
    chk("R1", "discard flag", discard_flag, 0);

    // directed read
    be_hold = 1;
    send(C_RD, 32'h0000_1230, 4'hF, 32'h0, r, rd);
    chk("R2", "first attempt retried", r, 1);
    chk("R2", "ready low in rsp cycle", fe_req_ready, 0);
    chk("R10", "waiting status", dt_status, 1);
    repeat (8) @(negedge clk);
    chk("R3", "one back-end request", be_cnt, 1);
    chk("R3", "captured address", pend_addr, 32'h0000_1230);
    chk("R3", "captured command", pend_cmd, C_RD);
    chk("R3", "captured byte enables", pend_be, 4'hF);
    send(C_RD, 32'h0000_1230, 4'hF, 32'h0, r, rd);
    chk("R4", "early repeat retried", r, 1);
    chk("R4", "still waiting", dt_status, 1);
    send(C_RD, 32'h0000_2000, 4'hF, 32'h0, r, rd);
    chk("R7", "foreign retried", r, 1);
    repeat (6) @(negedge clk);
    chk("R7", "no extra back-end request", be_cnt, 1);
    be_hold = 0;
    wait_status(2);
    chk("R10", "ready status", dt_status, 2);
    send(C_RD, 32'h0000_1230, 4'h3, 32'h0, r, rd);
    chk("R6", "byte-enable mismatch retried", r, 1);
    send(C_IORD, 32'h0000_1230, 4'hF, 32'h0, r, rd);
    chk("R6", "command mismatch retried", r, 1);
    send(C_RD, 32'h0000_1230, 4'hF, 32'h0, r, rd);
    chk("R5", "matching repeat completes", r, 0);
    chk("R5", "read data", rd, exp_rd(32'h0000_1230));
    chk("R5", "entry freed", dt_status, 0);

    // directed write
    send(C_WR, 32'h0000_4440, 4'h5, 32'hDEAD_BEEF, r, rd);
    chk("R2", "write first attempt retried", r, 1);
    wait_status(2);
    chk("R3", "write data to back end", pend_wdata, 32'hDEAD_BEEF);
    send(C_WR, 32'h0000_4440, 4'h5, 32'hDEAD_BEEE, r, rd);
    chk("R6", "write data mismatch retried", r, 1);
    send(C_WR, 32'h0000_4440, 4'h5, 32'hDEAD_BEEF, r, rd);
    chk("R5", "write completes", r, 0);
    chk("R5", "freed after write", dt_status, 0);

    // random phase
    for (int it = 0; it < 40; it++) begin
      int k = $urandom % 4;
      c = (k == 0) ? C_RD : (k == 1) ? C_WR : (k == 2) ? C_IORD : C_IOWR;
      a = $urandom & 32'h0000_FFFC; b = 4'($urandom); d = $urandom;
      be_lat = $urandom % 5;
      base = be_cnt;
      send(c, a, b, d, r, rd);
      chk("R2", "random first attempt retried", r, 1);
      if ($urandom % 2) begin
        send(c, a ^ 32'h0001_0000, b, d, r, rd);
        chk("R7", "random foreign retried", r, 1);
      end
      wait_status(2);
      chk("R3", "random single request", be_cnt, base + 1);
      send(c, a, b, d, r, rd);
      chk("R5", "random repeat completes", r, 0);
      if (!c[0]) chk("R5", "random read data", rd, exp_rd(a));
    end

    // discard window
    be_lat = 1;
    base = be_cnt;
    send(C_RD, 32'h0000_7700, 4'hF, 32'h0, r, rd);
    wait_status(2);
    repeat (LIMIT - 10) @(negedge clk);
    chk("R8", "held just before window", dt_status, 2);
    chk("R8", "flag clear before window", discard_flag, 0);
    repeat (20) @(negedge clk);
    chk("R8", "dropped after window", dt_status, 0);
    chk("R8", "flag set", discard_flag, 1);
    send(C_RD, 32'h0000_7700, 4'hF, 32'h0, r, rd);
    chk("R8", "repeat after drop is new attempt", r, 1);
    wait_status(2);
    chk("R8", "new back-end request", be_cnt, base + 2);
    send(C_RD, 32'h0000_7700, 4'hF, 32'h0, r, rd);
    chk("R5", "completes after re-capture", r, 0);

    // sticky clear
    chk("R9", "flag still set", discard_flag, 1);
    @(negedge clk); discard_clr = 1'b1;
    @(negedge clk); discard_clr = 1'b0;
    chk("R9", "flag cleared", discard_flag, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule